// File: doc/BRIEF.md
# Multithreaded VLIW Packet Issue Selector

This block is the issue-select stage of a multithreaded VLIW signal processor. Five hardware contexts each offer at most one ready instruction packet. A packet states how many operations it needs from each class of shared function unit: multiply-accumulate data ALUs, the bit-manipulation unit, bitfield units and address generation units. Each cycle the stage packs as many whole packets as the shared pool can hold. It never splits a packet. A packet that does not fit stays with its context and competes again in the next cycle.

The contexts are visited in a rotating order. The visit starts at the context after the one that was served first in the previous selection, so no context is always first. Each accepted packet receives a contiguous run of physical units in every class, in the order the contexts were accepted. The result is registered: grants and unit maps appear one cycle after the requests were sampled. The address-unit pool is a parameter of either two or four units. A single packet never asks for more than two address units. A four-unit pool therefore lets two address-heavy packets go out together.

Top module: `smt_issue_select`

## Requirements
- R1: Grants and unit maps are registered. The values visible after a rising edge reflect the requests sampled at that edge. A context that did not request at that edge is not granted.
- R2: A granted context holds exactly the number of units it asked for in every class. A context without a grant holds no unit.
- R3: In every class, the units handed out in one cycle never exceed the pool size, and each physical unit belongs to at most one context.
- R4: The scan starts at the context after the first context served in the last selection that granted anything. The start is unchanged after a cycle with no grant.
- R5: A packet whose demand exceeds the remaining capacity in any class is skipped whole. The scan goes on, and later packets that still fit are granted.
- R6: Inside a class, units are given out from index 0 upward with no gap, following the acceptance order. Map bit t*U+u (U = pool size of that class) means unit u is assigned to context t.
- R7: A context that is the only requester is always granted.
- R8: The address-unit pool holds 2 or 4 units. With 4 units, two packets that each need two address units are both granted in the same cycle. With 2 units, only one of them is granted.
- R9: A synchronous active-high reset clears all grants and maps and makes context 0 the first in the scan.
- R10: A skipped context that keeps the same packet asserted is granted in a later cycle when capacity allows.
- R11: Demand field of context t is req_dem[12t+11:12t], split into 3-bit counts: address [11:9], bitfield [8:6], bit-manipulation [5:3], MAC [2:0]. A legal packet has 1 to 6 operations, at most 2 address units, and no class count above its pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_vld | input | NCTX | Context t has a ready packet |
| req_dem | input | NCTX*12 | Per-context demand counts (layout in R11) |
| grant | output | NCTX | Context t issues this cycle |
| map_mac | output | NCTX*N_MAC | MAC unit assignment, bit t*N_MAC+u |
| map_bmu | output | NCTX*N_BMU | Bit-manipulation unit assignment |
| map_bfu | output | NCTX*N_BFU | Bitfield unit assignment |
| map_agu | output | NCTX*N_AGU | Address unit assignment |

## Verification
The assertions rely on every requesting context presenting a legal packet. A legal packet has one to six operations, no more than two address units, and no class count above its pool. The lone-requester and whole-packet properties hold only under that condition. The bench makes only such packets: the fixed vectors are chosen by hand to stay legal, and the random generator replaces any empty or oversized packet with a single MAC operation. Two copies of the block run on the same stimulus, one with each address-pool size, so the pairing rule for address units is exercised against the same request stream.

// File: rtl/smt_issue_pkg.sv
`timescale 1ns/1ps
package smt_issue_pkg;

    localparam int OPS_MAX     = 6;
    localparam int AGU_PKT_MAX = 2;
    localparam int CNT_W       = 3;
    localparam int DEM_W       = 4 * CNT_W;

    // demand of one packet, most significant field first
    typedef struct packed {
        logic [CNT_W-1:0] agu;
        logic [CNT_W-1:0] bfu;
        logic [CNT_W-1:0] bmu;
        logic [CNT_W-1:0] mac;
    } pkt_dem_t;

    function automatic int pkt_ops(pkt_dem_t d);
        return int'(d.agu) + int'(d.bfu) + int'(d.bmu) + int'(d.mac);
    endfunction

    // position of context i in a scan that starts at context p
    function automatic int ring_pos(int i, int p, int n);
        return (i >= p) ? i - p : i + n - p;
    endfunction

endpackage

// File: rtl/smt_fit_scan.sv
`timescale 1ns/1ps
module smt_fit_scan
    import smt_issue_pkg::*;
#(
    parameter int NCTX  = 5,
    parameter int N_MAC = 4,
    parameter int N_BMU = 1,
    parameter int N_BFU = 4,
    parameter int N_AGU = 2,
    parameter int PW    = 3
) (
    input  logic [NCTX-1:0] req_vld,
    input  pkt_dem_t        dem [NCTX],
    input  logic [PW-1:0]   ptr,
    output logic [NCTX-1:0] take,
    output logic            first_vld,
    output logic [PW-1:0]   first_idx
);

    always_comb begin
        int rm;
        int rb;
        int rf;
        int ra;
        int pos;
        rm        = N_MAC;
        rb        = N_BMU;
        rf        = N_BFU;
        ra        = N_AGU;
        pos       = 0;
        take      = '0;
        first_vld = 1'b0;
        first_idx = '0;
        for (int k = 0; k < NCTX; k++) begin
            for (int i = 0; i < NCTX; i++) begin
                pos = ring_pos(i, int'(ptr), NCTX);
                if (pos == k && req_vld[i]
                    && int'(dem[i].mac) <= rm && int'(dem[i].bmu) <= rb
                    && int'(dem[i].bfu) <= rf && int'(dem[i].agu) <= ra) begin
                    take[i] = 1'b1;
                    rm = rm - int'(dem[i].mac);
                    rb = rb - int'(dem[i].bmu);
                    rf = rf - int'(dem[i].bfu);
                    ra = ra - int'(dem[i].agu);
                    if (!first_vld) begin
                        first_vld = 1'b1;
                        first_idx = PW'(i);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/smt_unit_alloc.sv
`timescale 1ns/1ps
module smt_unit_alloc
    import smt_issue_pkg::*;
#(
    parameter int NCTX  = 5,
    parameter int NUNIT = 4,
    parameter int PW    = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCTX-1:0]         take,
    input  logic [CNT_W-1:0]        cnt [NCTX],
    input  logic [PW-1:0]           ptr,
    output logic [NCTX*NUNIT-1:0]   umap
);

    always_comb begin
        int base;
        base = 0;
        umap = '0;
        for (int i = 0; i < NCTX; i++) begin
            base = 0;
            for (int j = 0; j < NCTX; j++) begin
                if (take[j] && ring_pos(j, int'(ptr), NCTX) < ring_pos(i, int'(ptr), NCTX))
                    base = base + int'(cnt[j]);
            end
            if (take[i]) begin
                for (int u = 0; u < NUNIT; u++) begin
                    if (u >= base && u < base + int'(cnt[i]))
                        umap[i*NUNIT + u] = 1'b1;
                end
            end
        end
    end

    genvar u, t;
    generate
        for (u = 0; u < NUNIT; u++) begin : g_col
            logic [NCTX-1:0] col;
            for (t = 0; t < NCTX; t++) begin : g_bit
                assign col[t] = umap[t*NUNIT + u];
            end
            AST_UNIT_ONCE: assert property (@(posedge clk) disable iff (rst) $onehot0(col)); // R3
            if (u > 0) begin : g_fill
                AST_LOW_FILL: assert property (@(posedge clk) disable iff (rst)
                    (|col) |-> (|g_col[u-1].col)); // R6
            end
        end
    endgenerate

endmodule

// File: rtl/smt_issue_select.sv
`timescale 1ns/1ps
module smt_issue_select
    import smt_issue_pkg::*;
#(
    parameter int NCTX  = 5,
    parameter int N_MAC = 4,
    parameter int N_BMU = 1,
    parameter int N_BFU = 4,
    parameter int N_AGU = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NCTX-1:0]        req_vld,
    input  logic [NCTX*DEM_W-1:0]  req_dem,
    output logic [NCTX-1:0]        grant,
    output logic [NCTX*N_MAC-1:0]  map_mac,
    output logic [NCTX*N_BMU-1:0]  map_bmu,
    output logic [NCTX*N_BFU-1:0]  map_bfu,
    output logic [NCTX*N_AGU-1:0]  map_agu
);

    localparam int PW = (NCTX > 1) ? $clog2(NCTX) : 1;

    pkt_dem_t         dem     [NCTX];
    logic [CNT_W-1:0] cnt_mac [NCTX];
    logic [CNT_W-1:0] cnt_bmu [NCTX];
    logic [CNT_W-1:0] cnt_bfu [NCTX];
    logic [CNT_W-1:0] cnt_agu [NCTX];

    logic [PW-1:0]          ptr_q;
    logic [PW-1:0]          ptr_d;
    logic [NCTX-1:0]        take;
    logic                   first_vld;
    logic [PW-1:0]          first_idx;
    logic [NCTX*N_MAC-1:0]  um_mac;
    logic [NCTX*N_BMU-1:0]  um_bmu;
    logic [NCTX*N_BFU-1:0]  um_bfu;
    logic [NCTX*N_AGU-1:0]  um_agu;

    genvar i;
    generate
        for (i = 0; i < NCTX; i++) begin : g_unpack
            assign dem[i]     = pkt_dem_t'(req_dem[i*DEM_W +: DEM_W]);
            assign cnt_mac[i] = dem[i].mac;
            assign cnt_bmu[i] = dem[i].bmu;
            assign cnt_bfu[i] = dem[i].bfu;
            assign cnt_agu[i] = dem[i].agu;
        end
    endgenerate

    smt_fit_scan #(
        .NCTX(NCTX), .N_MAC(N_MAC), .N_BMU(N_BMU), .N_BFU(N_BFU), .N_AGU(N_AGU), .PW(PW)
    ) u_scan (
        .req_vld(req_vld), .dem(dem), .ptr(ptr_q),
        .take(take), .first_vld(first_vld), .first_idx(first_idx)
    );

    smt_unit_alloc #(.NCTX(NCTX), .NUNIT(N_MAC), .PW(PW)) u_alloc_mac (
        .clk(clk), .rst(rst), .take(take), .cnt(cnt_mac), .ptr(ptr_q), .umap(um_mac));
    smt_unit_alloc #(.NCTX(NCTX), .NUNIT(N_BMU), .PW(PW)) u_alloc_bmu (
        .clk(clk), .rst(rst), .take(take), .cnt(cnt_bmu), .ptr(ptr_q), .umap(um_bmu));
    smt_unit_alloc #(.NCTX(NCTX), .NUNIT(N_BFU), .PW(PW)) u_alloc_bfu (
        .clk(clk), .rst(rst), .take(take), .cnt(cnt_bfu), .ptr(ptr_q), .umap(um_bfu));
    smt_unit_alloc #(.NCTX(NCTX), .NUNIT(N_AGU), .PW(PW)) u_alloc_agu (
        .clk(clk), .rst(rst), .take(take), .cnt(cnt_agu), .ptr(ptr_q), .umap(um_agu));

    always_comb begin
        ptr_d = ptr_q;
        if (first_vld)
            ptr_d = (first_idx == PW'(NCTX - 1)) ? '0 : first_idx + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            grant   <= '0;
            map_mac <= '0;
            map_bmu <= '0;
            map_bfu <= '0;
            map_agu <= '0;
        end else begin
            ptr_q   <= ptr_d;
            grant   <= take;
            map_mac <= um_mac;
            map_bmu <= um_bmu;
            map_bfu <= um_bfu;
            map_agu <= um_agu;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (grant == '0 && map_mac == '0)); // R9
    AST_LONE_WINS: assert property (@(posedge clk) disable iff (rst)
        $onehot(req_vld) |=> (grant == $past(req_vld))); // R7

    generate
        for (i = 0; i < NCTX; i++) begin : g_chk
            AST_PKT_LEGAL: assert property (@(posedge clk) disable iff (rst)
                req_vld[i] |-> (pkt_ops(dem[i]) >= 1 && pkt_ops(dem[i]) <= OPS_MAX
                    && int'(dem[i].agu) <= AGU_PKT_MAX && int'(dem[i].mac) <= N_MAC
                    && int'(dem[i].bmu) <= N_BMU && int'(dem[i].bfu) <= N_BFU)); // R11
            AST_NO_REQ_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
                !req_vld[i] |=> !grant[i]); // R1
            AST_WHOLE_PKT: assert property (@(posedge clk) disable iff (rst)
                grant[i] |-> ($countones(map_mac[i*N_MAC +: N_MAC]) == int'($past(dem[i].mac))
                    && $countones(map_bmu[i*N_BMU +: N_BMU]) == int'($past(dem[i].bmu))
                    && $countones(map_bfu[i*N_BFU +: N_BFU]) == int'($past(dem[i].bfu))
                    && $countones(map_agu[i*N_AGU +: N_AGU]) == int'($past(dem[i].agu)))); // R2
            AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
                !grant[i] |-> (map_mac[i*N_MAC +: N_MAC] == '0 && map_bmu[i*N_BMU +: N_BMU] == '0
                    && map_bfu[i*N_BFU +: N_BFU] == '0 && map_agu[i*N_AGU +: N_AGU] == '0)); // R2
        end
    endgenerate

endmodule

// File: tb/test_smt_issue_select.sv
`timescale 1ns/1ps
module test_smt_issue_select;
    import smt_issue_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst;
    logic [4:0]  vld;
    logic [59:0] dem;
    logic [4:0]  g2, g4, bm2, bm4;
    logic [19:0] mm2, mm4, fm2, fm4, am4;
    logic [9:0]  am2;

    int nchk = 0;
    int nfail = 0;
    int pm2 = 0;
    int pm4 = 0;

    smt_issue_select i_smt_issue_select (
        .clk(clk), .rst(rst), .req_vld(vld), .req_dem(dem), .grant(g2),
        .map_mac(mm2), .map_bmu(bm2), .map_bfu(fm2), .map_agu(am2));

    smt_issue_select #(.N_AGU(4)) i_smt_issue_select_agu4 (
        .clk(clk), .rst(rst), .req_vld(vld), .req_dem(dem), .grant(g4),
        .map_mac(mm4), .map_bmu(bm4), .map_bfu(fm4), .map_agu(am4));

    typedef struct packed {
        logic [4:0]  v;
        logic [11:0] d4, d3, d2, d1, d0;
        logic [4:0]  g;
    } vec_t;

    // demand literals in octal: address, bitfield, bit-manipulation, MAC
    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{5'b00001, 12'o0000, 12'o0000, 12'o0000, 12'o0000, 12'o0004, 5'b00001},
        '{5'b11111, 12'o0010, 12'o0010, 12'o0002, 12'o0002, 12'o0004, 5'b01110},
        '{5'b10001, 12'o1000, 12'o0000, 12'o0000, 12'o0000, 12'o2000, 5'b10000},
        '{5'b10001, 12'o1000, 12'o0000, 12'o0000, 12'o0000, 12'o2000, 5'b00001},
        '{5'b00000, 12'o0000, 12'o0000, 12'o0000, 12'o0000, 12'o0000, 5'b00000},
        '{5'b00011, 12'o0000, 12'o0000, 12'o0000, 12'o1111, 12'o1111, 5'b00010},
        '{5'b11111, 12'o0101, 12'o0101, 12'o0101, 12'o0101, 12'o0101, 5'b11101},
        '{5'b00100, 12'o0000, 12'o0000, 12'o2301, 12'o0000, 12'o0000, 5'b00100},
        '{5'b11001, 12'o0010, 12'o0010, 12'o0000, 12'o0000, 12'o0003, 5'b01001}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [4:0] v, input logic [59:0] d, input int nagu, inout int p,
                         output logic [4:0] g, output logic [19:0] mm, output logic [4:0] bm,
                         output logic [19:0] fm, output logic [19:0] am);
        int rm, rb, rf, ra, first;
        rm = 4; rb = 1; rf = 4; ra = nagu; first = -1;
        g = '0; mm = '0; bm = '0; fm = '0; am = '0;
        for (int k = 0; k < 5; k++) begin
            int i, cm, cb, cf, ca;
            i  = (p + k) % 5;
            cm = int'(d[i*12 +: 3]);
            cb = int'(d[i*12+3 +: 3]);
            cf = int'(d[i*12+6 +: 3]);
            ca = int'(d[i*12+9 +: 3]);
            if (v[i] && cm <= rm && cb <= rb && cf <= rf && ca <= ra) begin
                g[i] = 1'b1;
                for (int j = 0; j < cm; j++) mm[i*4 + (4 - rm) + j] = 1'b1;
                for (int j = 0; j < cb; j++) bm[i + (1 - rb) + j] = 1'b1;
                for (int j = 0; j < cf; j++) fm[i*4 + (4 - rf) + j] = 1'b1;
                for (int j = 0; j < ca; j++) am[i*nagu + (nagu - ra) + j] = 1'b1;
                rm -= cm; rb -= cb; rf -= cf; ra -= ca;
                if (first < 0) first = i;
            end
        end
        if (first >= 0) p = (first + 1) % 5;
    endtask

    task automatic step(input logic [4:0] v, input logic [59:0] d, input string tag);
        logic [4:0]  eg2, eg4, eb2, eb4;
        logic [19:0] em2, em4, ef2, ef4, ea2, ea4;
        vld = v;
        dem = d;
        model(v, d, 2, pm2, eg2, em2, eb2, ef2, ea2);
        model(v, d, 4, pm4, eg4, em4, eb4, ef4, ea4);
        @(posedge clk);
        @(negedge clk);
        chk({tag, " grant"}, 32'(g2), 32'(eg2));
        chk({tag, " R6 mac map"}, 32'(mm2), 32'(em2));
        chk({tag, " R6 bmu map"}, 32'(bm2), 32'(eb2));
        chk({tag, " R6 bfu map"}, 32'(fm2), 32'(ef2));
        chk({tag, " R6 agu map"}, 32'(am2), 32'(ea2[9:0]));
        chk({tag, " R8 grant agu4"}, 32'(g4), 32'(eg4));
        chk({tag, " R2 maps agu4"}, {12'(mm4 ^ em4), 5'(bm4 ^ eb4), 15'(am4 ^ ea4)}, 32'd0);
        chk({tag, " R2 bfu agu4"}, 32'(fm4), 32'(ef4));
    endtask

    function automatic logic [11:0] rnd_pkt();
        int m, b, f, a;
        m = $urandom_range(0, 4);
        b = $urandom_range(0, 1);
        f = $urandom_range(0, 4);
        a = $urandom_range(0, 2);
        if (m + b + f + a == 0 || m + b + f + a > 6) begin
            m = 1; b = 0; f = 0; a = 0;
        end
        return {3'(a), 3'(f), 3'(b), 3'(m)};
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1;
        vld = '0;
        dem = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset grant", 32'(g2), 32'd0);
        chk("R9 reset maps", 32'(mm2 | fm2 | 20'(am2) | 20'(bm2)), 32'd0);
        rst = 1'b0;
        pm2 = 0;
        pm4 = 0;

        for (int n = 0; n < NVEC; n++) begin
            step(VECS[n].v, {VECS[n].d4, VECS[n].d3, VECS[n].d2, VECS[n].d1, VECS[n].d0},
                 "R4 R5 R10 table");
            chk("R4 R5 R10 hand grant", 32'(g2), 32'(VECS[n].g));
        end

        // R1: input change alone does not move the registered outputs
        vld = 5'b00010;
        dem = {48'd0, 12'o0004};
        #1;
        chk("R1 before edge", 32'(g2), 32'(VECS[NVEC-1].g));
        step(5'b00010, {36'd0, 12'o0004, 12'o0000}, "R1 R7 after edge");

        // R8: two address-pair packets
        step(5'b00011, {36'd0, 12'o2000, 12'o2000}, "R8 pair");
        chk("R8 pair agu4 both", 32'(g4), 32'b00011);
        chk("R8 pair agu2 single", 32'($countones(g2)), 32'd1);

        // R9: reset while requests are held, then scan starts at context 0
        rst = 1'b1;
        vld = 5'b11111;
        dem = {5{12'o0004}};
        @(posedge clk);
        @(negedge clk);
        chk("R9 reset under load", 32'(g2), 32'd0);
        rst = 1'b0;
        pm2 = 0;
        pm4 = 0;
        step(5'b11111, {5{12'o0004}}, "R9 restart");
        chk("R9 first after reset", 32'(g2), 32'b00001);

        for (int r = 0; r < 400; r++) begin
            logic [4:0]  rv;
            logic [59:0] rd;
            rv = 5'($urandom);
            for (int t = 0; t < 5; t++) rd[t*12 +: 12] = rnd_pkt();
            step(rv, rd, "R2 R3 R4 R5 random");
            chk("R3 mac total", 32'($countones(mm2) <= 4), 32'd1);
            chk("R3 agu total", 32'($countones(am2) <= 2), 32'd1);
            if ($onehot(rv)) chk("R7 lone", 32'(g2), 32'(rv));
        end

        summary();
    end

endmodule